// File: doc/BRIEF.md
# Push-Button Input Port with Capture and Interrupt

This block is a memory-mapped peripheral that connects a small group of active-low push buttons to a processor data bus. The bus uses a strobe, a write enable and an acknowledge. The block answers a window of four consecutive byte addresses. Reads from that window return one of three views: the live button lines, a snapshot of the button lines, or a fixed byte that confirms the bus wiring. No data is stored from a write. A write to the first address only tells the port to take a snapshot of the buttons on that cycle, so software can later read a coherent picture of every button at once.

One button line also serves as an interrupt source. The line is inverted, so a press reads as one, and it is registered on the system clock. An elaboration parameter selects one of two forms of the request. The level form stays high for as long as the button is held. The edge form gives a single-cycle pulse on each press, so a held button cannot keep requesting service.

Outside its window, and whenever the strobe is low, the port drives zero on its read data. Its output can therefore be ORed or multiplexed with the read data of other peripherals.

Top module: `btn_input_port`

## Requirements
- R1: The port responds only when the strobe is high and the address, with its two low bits ignored, equals the base address (default 0x48, so the window is 0x48 to 0x4B). Any other address, such as 0x47, 0x4C or 0xC8, produces no acknowledge and read data of 0x00.
- R2: The acknowledge rises on the clock edge after a strobed access in the window begins and stays high for exactly one cycle. The cycle after an acknowledge always has the acknowledge low.
- R3: While the port is selected at sub-address 0 (0x48), the read data equals the 4-bit button pins in bits 3:0, with bits 7:4 equal to zero.
- R4: A strobed write to sub-address 0 stores the button pins into the snapshot register on the edge that starts the access. Any write data is ignored. Writes to sub-addresses 1, 2 and 3 leave the snapshot unchanged.
- R5: While the port is selected at sub-address 1 (0x49), the read data equals the snapshot, zero-extended to 8 bits.
- R6: While the port is selected at sub-address 2 or 3 (0x4A, 0x4B), the read data equals the test pattern 0xAA.
- R7: When the strobe is low, the read data is 0x00 at every address.
- R8: A synchronous, active-high reset clears the snapshot to 0x0, the acknowledge to 0 and the interrupt request to 0.
- R9: In level mode (EDGE_IRQ = 0), the interrupt request equals the inverse of button pin 3, delayed by one clock edge.
- R10: In edge mode (EDGE_IRQ = 1), a press of button 3 (pin going from 1 to 0) raises the request for exactly one cycle, one edge after the press. Holding the button raises no further request, and each new press gives a new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_adr | input | ADDR_W | Byte address from the processor |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | High for a write, low for a read |
| btn_n | input | IN_W | Button lines, active low |
| bus_rdat | output | DATA_W | Read data, zero when the port is not selected |
| bus_ack | output | 1 | One-cycle access acknowledge |
| irq | output | 1 | Interrupt request derived from button pin 3 |

## Verification
The hardest case to reach is a write that must not take a snapshot. Two such writes matter: a write to a sub-address other than 0, and the later cycles of a strobe held past its acknowledge. In both, the snapshot has to keep its old value even though the pins have since changed. The bench first takes a snapshot, then changes the pins and writes to 0x49 and 0x4A. It then reads 0x49 and expects the first value. It also holds a strobe for several cycles to confirm that the cycle after an acknowledge is low. A second instance built in edge mode is held with button 3 pressed for many cycles, to show that only one pulse appears per press.

// File: rtl/btn_port_pkg.sv
package btn_port_pkg;

    localparam int SUB_W = 2;

    typedef enum logic [SUB_W-1:0] {
        VIEW_LIVE  = 2'd0,
        VIEW_HELD  = 2'd1,
        VIEW_PAT_A = 2'd2,
        VIEW_PAT_B = 2'd3
    } view_e;

    typedef struct packed {
        logic  hit;
        logic  first;
        logic  wr;
        view_e view;
    } access_t;

    function automatic logic window_match(input logic [31:0] adr, input logic [31:0] base);
        return (adr >> SUB_W) == (base >> SUB_W);
    endfunction

endpackage

// File: rtl/port_addr_dec.sv
module port_addr_dec
    import btn_port_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] adr,
    input  logic              stb,
    input  logic              we,
    output access_t           acc,
    output logic              ack
);

    logic ack_q;

    always_comb begin
        acc.hit   = stb && window_match(32'(adr), 32'(BASE_ADDR));
        acc.first = acc.hit && !ack_q;
        acc.wr    = we;
        acc.view  = view_e'(adr[SUB_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= acc.first;
    end

    assign ack = ack_q;

endmodule

// File: rtl/port_view_mux.sv
module port_view_mux
    import btn_port_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                IN_W     = 4,
    parameter logic [DATA_W-1:0] TEST_PAT = 8'hAA
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [IN_W-1:0]   pins,
    output logic [IN_W-1:0]   snap,
    output logic [DATA_W-1:0] rdat
);

    logic [IN_W-1:0] snap_q;
    logic            capture;

    assign capture = acc.first && acc.wr && (acc.view == VIEW_LIVE);

    always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (capture) snap_q <= pins;
    end

    always_comb begin
        rdat = '0;
        if (acc.hit) begin
            unique case (acc.view)
                VIEW_LIVE: rdat = DATA_W'(pins);
                VIEW_HELD: rdat = DATA_W'(snap_q);
                default:   rdat = TEST_PAT;
            endcase
        end
    end

    assign snap = snap_q;

endmodule

// File: rtl/port_irq_sync.sv
module port_irq_sync #(
    parameter bit EDGE_IRQ = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    output logic irq
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= ~line_n;
    end

    generate
        if (EDGE_IRQ) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= req_q;
            end
            assign irq = req_q & ~prev_q;
        end else begin : g_level
            assign irq = req_q;
        end
    endgenerate

endmodule

// File: rtl/btn_input_port.sv
module btn_input_port
    import btn_port_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                IN_W      = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h48,
    parameter int                IRQ_BIT   = 3,
    parameter logic [DATA_W-1:0] TEST_PAT  = 8'hAA,
    parameter bit                EDGE_IRQ  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_adr,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [IN_W-1:0]   btn_n,
    output logic [DATA_W-1:0] bus_rdat,
    output logic              bus_ack,
    output logic              irq
);

    access_t         acc;
    logic [IN_W-1:0] snap;

    port_addr_dec #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .clk(clk),
        .rst(rst),
        .adr(bus_adr),
        .stb(bus_stb),
        .we (bus_we),
        .acc(acc),
        .ack(bus_ack)
    );

    port_view_mux #(
        .DATA_W  (DATA_W),
        .IN_W    (IN_W),
        .TEST_PAT(TEST_PAT)
    ) u_mux (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .pins(btn_n),
        .snap(snap),
        .rdat(bus_rdat)
    );

    port_irq_sync #(
        .EDGE_IRQ(EDGE_IRQ)
    ) u_irq (
        .clk   (clk),
        .rst   (rst),
        .line_n(btn_n[IRQ_BIT]),
        .irq   (irq)
    );

endmodule

// File: rtl/btn_input_port_chk.sv
module btn_input_port_chk
    import btn_port_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                IN_W      = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h48,
    parameter int                IRQ_BIT   = 3,
    parameter logic [DATA_W-1:0] TEST_PAT  = 8'hAA,
    parameter bit                EDGE_IRQ  = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] adr,
    input logic              stb,
    input logic              we,
    input logic [IN_W-1:0]   pins,
    input logic [DATA_W-1:0] rdat,
    input logic              ack,
    input logic              irq,
    input logic [IN_W-1:0]   snap
);

    logic sel_w;
    logic grab_w;

    assign sel_w  = stb && ((adr >> SUB_W) == (BASE_ADDR >> SUB_W));
    assign grab_w = sel_w && we && (adr[SUB_W-1:0] == '0) && !ack;

    // R1
    ack_window_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(sel_w));

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_w |-> rdat == '0);

    // R3
    live_view_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_w && adr[SUB_W-1:0] == '0) |-> rdat == DATA_W'(pins));

    // R6
    pattern_view_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_w && adr[1]) |-> rdat == TEST_PAT);

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        grab_w |=> snap == $past(pins));

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !grab_w |=> $stable(snap));

    generate
        if (EDGE_IRQ) begin : g_edge_chk
            // R10
            irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
                irq |=> !irq);
        end else begin : g_level_chk
            // R9
            irq_level_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> irq == !$past(pins[IRQ_BIT]));
        end
    endgenerate

endmodule

bind btn_input_port btn_input_port_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IN_W     (IN_W),
    .BASE_ADDR(BASE_ADDR),
    .IRQ_BIT  (IRQ_BIT),
    .TEST_PAT (TEST_PAT),
    .EDGE_IRQ (EDGE_IRQ)
) u_chk (
    .clk (clk),
    .rst (rst),
    .adr (bus_adr),
    .stb (bus_stb),
    .we  (bus_we),
    .pins(btn_n),
    .rdat(bus_rdat),
    .ack (bus_ack),
    .irq (irq),
    .snap(snap)
);

// File: tb/tb_btn_input_port.sv
module tb_btn_input_port;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 15;

    // vector: {adr[7:0], we, pins[3:0], exp_rdat[7:0], exp_ack}
    localparam logic [21:0] VECS [N_VEC] = '{
        {8'h49, 1'b0, 4'hA, 8'h00, 1'b1},
        {8'h48, 1'b0, 4'h5, 8'h05, 1'b1},
        {8'h48, 1'b1, 4'h9, 8'h09, 1'b1},
        {8'h49, 1'b0, 4'h3, 8'h09, 1'b1},
        {8'h4A, 1'b0, 4'h3, 8'hAA, 1'b1},
        {8'h4B, 1'b0, 4'h3, 8'hAA, 1'b1},
        {8'h49, 1'b1, 4'h6, 8'h09, 1'b1},
        {8'h49, 1'b0, 4'h6, 8'h09, 1'b1},
        {8'h4A, 1'b1, 4'h0, 8'hAA, 1'b1},
        {8'h49, 1'b0, 4'h0, 8'h09, 1'b1},
        {8'h47, 1'b0, 4'h5, 8'h00, 1'b0},
        {8'h4C, 1'b0, 4'h5, 8'h00, 1'b0},
        {8'hC8, 1'b0, 4'h5, 8'h00, 1'b0},
        {8'h48, 1'b1, 4'hF, 8'h0F, 1'b1},
        {8'h49, 1'b0, 4'h0, 8'h0F, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_adr = 8'h00;
    logic       bus_stb = 1'b0;
    logic       bus_we  = 1'b0;
    logic [3:0] btn_n   = 4'hF;
    logic [7:0] rdat, rdat_e;
    logic       ack, ack_e;
    logic       irq, irq_e;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_input_port dut (
        .clk(clk), .rst(rst), .bus_adr(bus_adr), .bus_stb(bus_stb),
        .bus_we(bus_we), .btn_n(btn_n), .bus_rdat(rdat), .bus_ack(ack), .irq(irq)
    );

    btn_input_port #(.EDGE_IRQ(1'b1)) dut_edge (
        .clk(clk), .rst(rst), .bus_adr(bus_adr), .bus_stb(bus_stb),
        .bus_we(bus_we), .btn_n(btn_n), .bus_rdat(rdat_e), .bus_ack(ack_e), .irq(irq_e)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_op(input logic [7:0] a, input logic w, output logic [7:0] rd, output logic ak);
        @(negedge clk);
        bus_adr = a; bus_we = w; bus_stb = 1'b1;
        @(negedge clk);
        rd = rdat; ak = ack;
        bus_stb = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [7:0] a, input logic w, input logic ak);
        if (!ak)             return "R1";
        if (a[1:0] == 2'd0)  return w ? "R4" : "R3";
        if (a[1:0] == 2'd1)  return "R5";
        return "R6";
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        logic       ak;

        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 ack in reset", 32'(ack), 0);
        check("R8 irq in reset", 32'(irq), 0);
        check("R8 edge irq in reset", 32'(irq_e), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 ack after reset", 32'(ack), 0);

        // R7: strobe low gives zero read data at an in-window address
        bus_adr = 8'h4A; #1;
        check("R7 idle rdata", 32'(rdat), 0);
        bus_adr = 8'h48; #1;
        check("R7 idle rdata raw addr", 32'(rdat), 0);

        // table walk (first entry reads the reset snapshot, R8)
        for (int i = 0; i < N_VEC; i++) begin
            logic [7:0] va;
            logic       vw;
            va = VECS[i][21:14];
            vw = VECS[i][13];
            btn_n = VECS[i][12:9];
            bus_op(va, vw, rd, ak);
            check({tag_of(va, vw, VECS[i][0]), " rdat"}, 32'(rd), 32'(VECS[i][8:1]));
            check({tag_of(va, vw, VECS[i][0]), " ack"}, 32'(ak), 32'(VECS[i][0]));
            check("R2 ack low after access", 32'(ack), 0);
        end

        // R2: strobe held over several cycles
        @(negedge clk);
        bus_adr = 8'h4B; bus_we = 1'b0; bus_stb = 1'b1;
        @(negedge clk);
        check("R2 ack first cycle", 32'(ack), 1);
        @(negedge clk);
        check("R2 ack cycle after ack", 32'(ack), 0);
        bus_stb = 1'b0;

        // R4: held strobe on a capture write takes only the first-cycle pins
        @(negedge clk);
        btn_n = 4'h2;
        bus_adr = 8'h48; bus_we = 1'b1; bus_stb = 1'b1;
        @(negedge clk);
        btn_n = 4'hC;
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
        bus_op(8'h49, 1'b0, rd, ak);
        check("R4 held write snapshot", 32'(rd), 32'h02);

        // R9 and R10: interrupt forms
        btn_n = 4'hF;
        repeat (3) @(negedge clk);
        btn_n = 4'h7; #1;
        check("R9 irq before edge", 32'(irq), 0);
        @(negedge clk);
        check("R9 irq level high", 32'(irq), 1);
        check("R10 edge pulse", 32'(irq_e), 1);
        @(negedge clk);
        check("R10 edge pulse ends", 32'(irq_e), 0);
        repeat (5) @(negedge clk);
        check("R9 irq level held", 32'(irq), 1);
        check("R10 no retrigger while held", 32'(irq_e), 0);
        btn_n = 4'hF;
        @(negedge clk);
        check("R9 irq released", 32'(irq), 0);
        check("R10 edge after release", 32'(irq_e), 0);
        @(negedge clk);
        btn_n = 4'h7;
        @(negedge clk);
        check("R10 second press pulse", 32'(irq_e), 1);

        // R8: reset clears snapshot again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 irq cleared", 32'(irq), 0);
        rst = 1'b0;
        btn_n = 4'hF;
        bus_op(8'h49, 1'b0, rd, ak);
        check("R8 snapshot cleared", 32'(rd), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule